// File: doc/BRIEF.md
# Key-gated flash control and status register

This block is one byte-wide control and status register for an on-chip flash programming and erasing controller, with its unlock key register alongside it. Both sit on a simple register bus that carries an address, a write strobe, write data and combinational read data. The status byte shows the live level of the hardware write-enable pin. It also shows a sticky error flag that locks out programming, and a download-request bit that starts copying a program image into RAM.

A download request is honoured only when four things hold. The key register must be armed with the unlock value. RAM emulation must be off. The writing access must come from a fetch in on-chip RAM. No error may be latched. An accepted request sends a one-cycle start pulse to an external download engine. The request bit then reads 1 until that engine reports completion.

The error flag is latched from an internal error-detect input. It drives a program/erase enable output low and raises a hint asking the reset controller for a longer reset. Software standby re-initialises the key and the request, but it does not clear the error flag. Only power-on reset or hardware standby clears it.

Top module: `flash_ctl_reg`

## Requirements
- R1: After power-on reset the control byte reads with only bit 7 possibly set (equal to the pin), the key address reads 0x00, dl_start is 0 and ext_reset_hint is 0.
- R2: Bit 7 of the control byte always equals the current level of wen_pin, in the same cycle.
- R3: Bits 6, 5, 3, 2 and 1 of the control byte always read 0. Writing 1 to them changes nothing that can be read.
- R4: A high err_detect sets the error flag (control bit 4, and ext_reset_hint) at the next clock edge. The flag then stays set through any bus write and through software standby.
- R5: The error flag is cleared by power-on reset (por_n low) or by hw_stby high at a clock edge, and by nothing else.
- R6: A write to the control address with bit 0 set that is accepted makes dl_start high for exactly the cycle after the write edge. Control bit 0 then reads 1 until dl_done is sampled high, and reads 0 from the following edge.
- R7: A download write is ignored (no pulse, bit 0 stays 0) if the key is not armed, if ram_emu_on is 1, if fetch_in_ram is 0, if the error flag is set, or if a standby input is high.
- R8: Writing exactly 0xA5 to the key address arms the key, and the key address then reads 0xA5. A write of any other value disarms it, and it then reads 0x00.
- R9: sw_stby or hw_stby high at a clock edge disarms the key and clears the request bit.
- R10: pe_enable equals wen_pin AND NOT error flag, and ext_reset_hint equals the error flag.
- R11: A download write while a request is still pending produces no further start pulse.
- R12: Addresses other than the control and key addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_stby | input | 1 | Hardware standby, synchronous clear of all state |
| sw_stby | input | 1 | Software standby, clears key and request, keeps error |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr |
| fetch_in_ram | input | 1 | Current access comes from a fetch in on-chip RAM |
| ram_emu_on | input | 1 | RAM emulation active |
| wen_pin | input | 1 | Hardware write-enable pin level |
| err_detect | input | 1 | Internal program/erase error event |
| dl_done | input | 1 | Download engine finished |
| dl_start | output | 1 | One-cycle download start pulse |
| pe_enable | output | 1 | Program/erase permitted |
| ext_reset_hint | output | 1 | Request for an extended reset while the error is latched |

## Verification
The bench builds the block with its default parameters: a 2-bit address with the control byte at 0, the key at 1 and the unlock value 0xA5. With these values addresses 2 and 3 can be reached as unmapped locations, so the zero-read rule is tested too. The table of key values and mode conditions places each single failing condition of the download gate next to the accepted case. The directed tests cover the standby differences that the table cannot reach: error kept through software standby, error cleared by hardware standby and by power-on.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned BIT_WEN = 7;
  localparam int unsigned BIT_ERR = 4;
  localparam int unsigned BIT_REQ = 0;

  // Compose the control byte; every other bit is reserved and zero.
  function automatic logic [REG_W-1:0] pack_status(logic wen, logic err, logic req);
    logic [REG_W-1:0] v;
    v          = '0;
    v[BIT_WEN] = wen;
    v[BIT_ERR] = err;
    v[BIT_REQ] = req;
    return v;
  endfunction

  function automatic logic key_matches(logic [REG_W-1:0] v, logic [REG_W-1:0] k);
    return v == k;
  endfunction
endpackage

// File: rtl/flash_key_reg.sv
module flash_key_reg
  import flash_ctl_pkg::*;
#(
  parameter logic [REG_W-1:0] UNLOCK_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             armed
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   armed <= 1'b0;
    else if (clr) armed <= 1'b0;
    else if (wr)  armed <= key_matches(wdata, UNLOCK_KEY);
  end
endmodule

// File: rtl/flash_err_latch.sv
module flash_err_latch (
  input  logic clk,
  input  logic por_n,
  input  logic hw_stby,
  input  logic err_detect,
  output logic err_flag
);
  // Software standby is deliberately not an input here.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          err_flag <= 1'b0;
    else if (hw_stby)    err_flag <= 1'b0;
    else if (err_detect) err_flag <= 1'b1;
  end
endmodule

// File: rtl/flash_dl_req.sv
module flash_dl_req (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic accept,
  input  logic done,
  output logic req,
  output logic start
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req   <= 1'b0;
      start <= 1'b0;
    end else if (clr) begin
      req   <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= accept;
      if (accept)         req <= 1'b1;
      else if (req && done) req <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ctl_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 2'd1,
  parameter logic [REG_W-1:0] UNLOCK_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              fetch_in_ram,
  input  logic              ram_emu_on,
  input  logic              wen_pin,
  input  logic              err_detect,
  input  logic              dl_done,
  output logic              dl_start,
  output logic              pe_enable,
  output logic              ext_reset_hint
);
  logic standby;
  logic wr_ctrl;
  logic wr_key;
  logic key_armed;
  logic err_flag;
  logic req_pending;
  logic wr_accept;

  assign standby = hw_stby | sw_stby;
  assign wr_ctrl = bus_we && (bus_addr == CTRL_ADDR);
  assign wr_key  = bus_we && (bus_addr == KEY_ADDR);

  // Download gate: request bit, key, mode, fetch region, no error, idle.
  assign wr_accept = wr_ctrl && bus_wdata[BIT_REQ] && key_armed && !ram_emu_on &&
                     fetch_in_ram && !err_flag && !req_pending && !standby;

  flash_key_reg #(.UNLOCK_KEY(UNLOCK_KEY)) u_key (
    .clk   (clk),
    .por_n (por_n),
    .clr   (standby),
    .wr    (wr_key),
    .wdata (bus_wdata),
    .armed (key_armed)
  );

  flash_err_latch u_err (
    .clk        (clk),
    .por_n      (por_n),
    .hw_stby    (hw_stby),
    .err_detect (err_detect),
    .err_flag   (err_flag)
  );

  flash_dl_req u_req (
    .clk    (clk),
    .por_n  (por_n),
    .clr    (standby),
    .accept (wr_accept),
    .done   (dl_done),
    .req    (req_pending),
    .start  (dl_start)
  );

  always_comb begin
    if (bus_addr == CTRL_ADDR)     bus_rdata = pack_status(wen_pin, err_flag, req_pending);
    else if (bus_addr == KEY_ADDR) bus_rdata = key_armed ? UNLOCK_KEY : '0;
    else                           bus_rdata = '0;
  end

  assign pe_enable      = wen_pin & ~err_flag;
  assign ext_reset_hint = err_flag;
endmodule

// File: rtl/flash_ctl_reg_chk.sv
module flash_ctl_reg_chk
  import flash_ctl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'd0
) (
  input logic              clk,
  input logic              por_n,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              fetch_in_ram,
  input logic              ram_emu_on,
  input logic              wen_pin,
  input logic              err_detect,
  input logic              dl_start,
  input logic              pe_enable,
  input logic              ext_reset_hint,
  input logic              wr_accept
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    dl_start |=> !dl_start); // R6
  AST_ACCEPT_PULSES: assert property (@(posedge clk) disable iff (!por_n)
    wr_accept && !hw_stby && !sw_stby |=> dl_start); // R6
  AST_START_GATED: assert property (@(posedge clk) disable iff (!por_n)
    dl_start |-> $past(bus_we && bus_addr == CTRL_ADDR && bus_wdata[0] && !ram_emu_on &&
                       fetch_in_ram && !ext_reset_hint && !sw_stby && !hw_stby)); // R7
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!por_n)
    err_detect && !hw_stby |=> ext_reset_hint); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ext_reset_hint && !hw_stby |=> ext_reset_hint); // R5
  AST_PE_GATED: assert property (@(posedge clk) disable iff (!por_n)
    pe_enable |-> wen_pin && !ext_reset_hint); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    bus_addr == CTRL_ADDR |-> (bus_rdata & 8'h6E) == 8'h00); // R3
  AST_WEN_MIRROR: assert property (@(posedge clk) disable iff (!por_n)
    bus_addr == CTRL_ADDR |-> bus_rdata[7] == wen_pin); // R2
endmodule

bind flash_ctl_reg flash_ctl_reg_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (.*);

// File: tb/flash_ctl_reg_tb.sv
`timescale 1ns/1ps
module flash_ctl_reg_tb;
  logic       clk = 1'b0;
  logic       por_n, hw_stby, sw_stby, bus_we, fetch_in_ram, ram_emu_on;
  logic       wen_pin, err_detect, dl_done;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       dl_start, pe_enable, ext_reset_hint;
  int         checks = 0;
  int         fails  = 0;
  int         cycles = 0;

  // {key value, ram_emu_on, fetch_in_ram, expected start}
  localparam logic [10:0] VEC [7] = '{
    {8'hA5, 1'b0, 1'b1, 1'b1},
    {8'hA5, 1'b1, 1'b1, 1'b0},
    {8'hA5, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b0},
    {8'hA4, 1'b0, 1'b1, 1'b0},
    {8'hA5, 1'b0, 1'b1, 1'b1}
  };

  always #5 clk = ~clk;

  flash_ctl_reg u_dut (
    .clk(clk), .por_n(por_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fetch_in_ram(fetch_in_ram), .ram_emu_on(ram_emu_on), .wen_pin(wen_pin),
    .err_detect(err_detect), .dl_done(dl_done), .dl_start(dl_start),
    .pe_enable(pe_enable), .ext_reset_hint(ext_reset_hint)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r;
    por_n = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; bus_we = 1'b0; bus_addr = 2'd0;
    bus_wdata = 8'h00; fetch_in_ram = 1'b1; ram_emu_on = 1'b0; wen_pin = 1'b1;
    err_detect = 1'b0; dl_done = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1 reset values
    rd(2'd0, r); check("R1 ctrl", r, 8'h80);
    rd(2'd1, r); check("R1 key", r, 8'h00);
    check("R1 start", {7'b0, dl_start}, 8'h00);
    check("R1 hint", {7'b0, ext_reset_hint}, 8'h00);

    // R2 pin mirror
    wen_pin = 1'b0; rd(2'd0, r); check("R2 low", r, 8'h00);
    check("R10 pe low pin", {7'b0, pe_enable}, 8'h00);
    wen_pin = 1'b1; rd(2'd0, r); check("R2 high", r, 8'h80);
    check("R10 pe high pin", {7'b0, pe_enable}, 8'h01);

    // R12 unmapped addresses
    rd(2'd2, r); check("R12 addr2", r, 8'h00);
    rd(2'd3, r); check("R12 addr3", r, 8'h00);

    // Table walk: R7 R8 R6
    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][10:3]);
      rd(2'd1, r); check("R8 key read", r, (VEC[i][10:3] == 8'hA5) ? 8'hA5 : 8'h00);
      ram_emu_on = VEC[i][2]; fetch_in_ram = VEC[i][1];
      wr(2'd0, 8'h01);
      check(VEC[i][0] ? "R6 start" : "R7 blocked", {7'b0, dl_start}, {7'b0, VEC[i][0]});
      rd(2'd0, r); check("R6 req bit", r, {7'h40, VEC[i][0]});
      @(negedge clk);
      check("R6 pulse one cycle", {7'b0, dl_start}, 8'h00);
      if (VEC[i][0]) begin
        rd(2'd0, r); check("R6 req held", r, 8'h81);
        pulse(dl_done);
        rd(2'd0, r); check("R6 req cleared", r, 8'h80);
      end
      ram_emu_on = 1'b0; fetch_in_ram = 1'b1;
    end

    // R3 reserved bits: key armed, write 0xFE (no request)
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'hFE);
    rd(2'd0, r); check("R3 reserved", r, 8'h80);
    check("R3 no start", {7'b0, dl_start}, 8'h00);

    // R11 pending request blocks another
    wr(2'd0, 8'hFF);
    check("R11 first start", {7'b0, dl_start}, 8'h01);
    rd(2'd0, r); check("R3 reserved after FF", r, 8'h81);
    wr(2'd0, 8'h01);
    check("R11 no second start", {7'b0, dl_start}, 8'h00);

    // R9 software standby clears key and request
    pulse(sw_stby);
    rd(2'd0, r); check("R9 req cleared", r, 8'h80);
    rd(2'd1, r); check("R9 key cleared", r, 8'h00);

    // R4 error latch
    wr(2'd1, 8'hA5);
    pulse(err_detect);
    rd(2'd0, r); check("R4 err set", r, 8'h90);
    check("R10 hint", {7'b0, ext_reset_hint}, 8'h01);
    check("R10 pe off", {7'b0, pe_enable}, 8'h00);
    wr(2'd0, 8'h01);
    check("R7 err blocks", {7'b0, dl_start}, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, r); check("R4 write keeps err", r, 8'h90);
    pulse(sw_stby);
    rd(2'd0, r); check("R4 sw standby keeps err", r, 8'h90);

    // R5 hardware standby clears error and key (R9)
    pulse(hw_stby);
    rd(2'd0, r); check("R5 hw standby clears", r, 8'h80);
    rd(2'd1, r); check("R9 hw key cleared", r, 8'h00);

    // R5 power-on clears error
    pulse(err_detect);
    check("R4 err again", {7'b0, ext_reset_hint}, 8'h01);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(2'd0, r); check("R5 por clears", r, 8'h80);

    // R7 standby during request write
    wr(2'd1, 8'hA5);
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'h01; sw_stby = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; sw_stby = 1'b0;
    check("R7 standby blocks", {7'b0, dl_start}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule